// File: doc/BRIEF.md
# Single-Flag Compare and Branch Unit

This block is the condition part of a small RISC execution stage. It keeps one status bit, T, and only the two compare operations ever write it. It takes a decoded operation code, two 32-bit register operands, an 8-bit immediate field from the instruction word and the current program counter. For each operation it accepts, it produces one result:

- an add-with-immediate sum, which never disturbs T;
- a compare outcome, which shows up in T;
- a branch decision with a taken flag and a target address.

Operations arrive on a valid/ready stream and results leave on a second valid/ready stream. The result stage holds a single entry. An input is accepted only when that entry is empty or is being drained in the same cycle (`in_ready = !out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the result is frozen and no new operation enters. An operation that has not been accepted has no effect, and T changes only at the edge where a compare is accepted. A counted loop therefore takes three steps: an add of -1, a compare-equal against zero, and a branch on T.

Top module: `tflag_branch_unit`

## Requirements
- R1: After reset, `t_flag` is 0, `out_valid` is 0 and `in_ready` is 1.
- R2: An accepted signed greater-or-equal compare (code 2) sets `t_flag` to 1 when `in_rn` >= `in_rm`, both taken as signed 32-bit values, and clears it otherwise. The new value is visible on the cycle after acceptance.
- R3: An accepted equal-to-immediate compare (code 3) sets `t_flag` when `in_rn` equals the sign-extended 8-bit `in_imm`, and clears it otherwise.
- R4: An accepted add-immediate (code 1) returns `out_sum` = `in_rn` + sign-extended `in_imm` (modulo 2^32) and leaves `t_flag` unchanged.
- R5: A branch-on-true (code 4) gives `out_taken` = 1 exactly when T is 1. A branch-on-false (code 5) gives `out_taken` = 1 exactly when T is 0. The T used is the value left by all earlier accepted operations.
- R6: For codes 4 and 5, `out_target` = `in_pc` + 4 + 2 * sign-extended `in_imm` (modulo 2^32).
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0. The outputs `out_sum`, `out_taken`, `out_target` and `out_op` stay unchanged, and T is not written.
- R8: Code 0 and the unused codes 6 and 7 produce a result with `out_sum` = 0 and `out_taken` = 0, and they leave T unchanged.
- R9: A loop that repeats add -1, compare-equal with 0 and branch-on-true exits on the iteration where the register reaches zero, after exactly as many iterations as the starting count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation accepted this cycle if valid |
| in_op | input | 3 | Operation code (0 none, 1 add-imm, 2 cmp-ge, 3 cmp-eq-imm, 4 branch-true, 5 branch-false) |
| in_rn | input | 32 | First register operand |
| in_rm | input | 32 | Second register operand |
| in_imm | input | 8 | Immediate field, also the branch displacement |
| in_pc | input | 32 | Program counter of the operation |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_op | output | 3 | Code of the operation the result belongs to |
| out_sum | output | 32 | Add-immediate sum, 0 for other codes |
| out_taken | output | 1 | Branch taken |
| out_target | output | 32 | Branch target address, 0 for non-branches |
| t_flag | output | 1 | Current T bit |

## Verification
Every result appears on the output register one clock edge after its operation is accepted, and T changes at that same edge. The bench therefore drives each operation on a falling edge, lets exactly one rising edge pass, and samples `out_*` and `t_flag` on the next falling edge. A branch issued right after a compare is sampled the same way, which checks that it sees the T written one edge before. For back-pressure, the bench samples across several stalled edges and confirms that nothing moved before it releases `out_ready`.

// File: rtl/tflag_pkg.sv
package tflag_pkg;
  localparam int XLEN   = 32;
  localparam int IMM_W  = 8;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NONE  = 3'd0,
    OP_ADDI  = 3'd1,
    OP_CMPGE = 3'd2,
    OP_CMPEQ = 3'd3,
    OP_BRT   = 3'd4,
    OP_BRF   = 3'd5
  } op_e;
endpackage

// File: rtl/tflag_sext.sv
module tflag_sext #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int PAD = OUT_W - IN_W;
  generate
    if (PAD > 0) begin : g_pad
      assign dout = {{PAD{din[IN_W-1]}}, din};
    end else begin : g_nopad
      assign dout = din[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/tflag_compare.sv
module tflag_compare #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] k,
  output logic         ge,
  output logic         eq
);
  assign ge = $signed(a) >= $signed(b);
  assign eq = (a == k);
endmodule

// File: rtl/tflag_flag_reg.sv
module tflag_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  output logic t
);
  always_ff @(posedge clk) begin
    if (!rst_n)     t <= 1'b0;
    else if (wr_en) t <= wr_val;
  end
endmodule

// File: rtl/tflag_branch.sv
module tflag_branch #(
  parameter int W = 32
) (
  input  logic         is_brt,
  input  logic         is_brf,
  input  logic         t,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] disp,
  output logic         taken,
  output logic [W-1:0] target
);
  localparam logic [W-1:0] STEP = W'(4);
  assign taken  = (is_brt & t) | (is_brf & ~t);
  assign target = (is_brt | is_brf) ? (pc + STEP + {disp[W-2:0], 1'b0}) : '0;
endmodule

// File: rtl/tflag_branch_unit.sv
module tflag_branch_unit
  import tflag_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int IW = IMM_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_op,
  input  logic [W-1:0]    in_rn,
  input  logic [W-1:0]    in_rm,
  input  logic [IW-1:0]   in_imm,
  input  logic [W-1:0]    in_pc,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OP_W-1:0] out_op,
  output logic [W-1:0]    out_sum,
  output logic            out_taken,
  output logic [W-1:0]    out_target,
  output logic            t_flag
);
  logic         accept;
  logic [W-1:0] imm_x;
  logic         ge, eq;
  logic         is_add, is_ge, is_eq, is_brt, is_brf;
  logic         flag_we, flag_val;
  logic         br_taken;
  logic [W-1:0] br_target;
  logic [W-1:0] add_res;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  assign is_add = (in_op == OP_ADDI);
  assign is_ge  = (in_op == OP_CMPGE);
  assign is_eq  = (in_op == OP_CMPEQ);
  assign is_brt = (in_op == OP_BRT);
  assign is_brf = (in_op == OP_BRF);

  tflag_sext #(.IN_W(IW), .OUT_W(W)) u_sext (
    .din  (in_imm),
    .dout (imm_x)
  );

  tflag_compare #(.W(W)) u_cmp (
    .a  (in_rn),
    .b  (in_rm),
    .k  (imm_x),
    .ge (ge),
    .eq (eq)
  );

  assign flag_we  = accept && (is_ge || is_eq);
  assign flag_val = is_ge ? ge : eq;

  tflag_flag_reg u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (flag_we),
    .wr_val (flag_val),
    .t      (t_flag)
  );

  tflag_branch #(.W(W)) u_br (
    .is_brt (is_brt),
    .is_brf (is_brf),
    .t      (t_flag),
    .pc     (in_pc),
    .disp   (imm_x),
    .taken  (br_taken),
    .target (br_target)
  );

  assign add_res = is_add ? (in_rn + imm_x) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_op     <= '0;
      out_sum    <= '0;
      out_taken  <= 1'b0;
      out_target <= '0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_op     <= in_op;
      out_sum    <= add_res;
      out_taken  <= br_taken;
      out_target <= br_target;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/tflag_branch_unit_chk.sv
module tflag_branch_unit_chk
  import tflag_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int IW = IMM_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [OP_W-1:0] in_op,
  input logic [W-1:0]    in_rn,
  input logic [W-1:0]    in_rm,
  input logic [IW-1:0]   in_imm,
  input logic [W-1:0]    in_pc,
  input logic            out_valid,
  input logic            out_ready,
  input logic [OP_W-1:0] out_op,
  input logic [W-1:0]    out_sum,
  input logic            out_taken,
  input logic [W-1:0]    out_target,
  input logic            t_flag
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R2
  cmpge_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_CMPGE) |=> (t_flag == ($signed($past(in_rn)) >= $signed($past(in_rm)))));

  // R4
  add_keeps_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_ADDI) |=> $stable(t_flag));

  // R5
  brt_follows_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_BRT) |=> (out_taken == t_flag));

  // R5
  brf_follows_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_BRF) |=> (out_taken == !t_flag));

  // R6
  target_calc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == OP_BRT || in_op == OP_BRF)) |=>
      (out_target == $past(in_pc) + W'(4) + (W'($signed($past(in_imm))) << 1)));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_taken)
                                   && $stable(out_target) && $stable(out_op)));

  // R7
  no_accept_no_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(t_flag));

  // R8
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == 3'd0 || in_op == 3'd6 || in_op == 3'd7)) |=>
      ($stable(t_flag) && !out_taken && out_sum == '0));
endmodule

bind tflag_branch_unit tflag_branch_unit_chk #(.W(W), .IW(IW)) u_chk (.*);

// File: tb/sim_tflag_branch_unit.sv
module sim_tflag_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [2:0]  in_op;
  logic [31:0] in_rn, in_rm, in_pc;
  logic [7:0]  in_imm;
  logic        out_valid, out_ready;
  logic [2:0]  out_op;
  logic [31:0] out_sum, out_target;
  logic        out_taken, t_flag;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  bit model_t = 0;

  always #5 clk = ~clk;

  tflag_branch_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rn(in_rn), .in_rm(in_rm), .in_imm(in_imm), .in_pc(in_pc),
    .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op), .out_sum(out_sum),
    .out_taken(out_taken), .out_target(out_target), .t_flag(t_flag)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [7:0] v);
    return {{24{v[7]}}, v};
  endfunction

  // drive on a falling edge, one rising edge accepts, sample on the next falling edge
  task automatic issue(input logic [2:0] op, input logic [31:0] rn, input logic [31:0] rm,
                       input logic [7:0] imm, input logic [31:0] pc);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_rn = rn; in_rm = rm; in_imm = imm; in_pc = pc;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic branch_pair(input string tag);
    issue(3'd4, 0, 0, 8'd2, 32'h100);
    check(out_taken == model_t, {tag, " R5 brt"}, {31'd0, out_taken}, {31'd0, model_t});
    issue(3'd5, 0, 0, 8'd2, 32'h100);
    check(out_taken == !model_t, {tag, " R5 brf"}, {31'd0, out_taken}, {31'd0, !model_t});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] vals [7];
    logic [7:0]  imms [6];
    logic [31:0] held;
    int iters;
    logic [31:0] r;

    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'hFFFF_FFFF; vals[3] = 32'h2;
    vals[4] = 32'hFFFF_FFFE; vals[5] = 32'h7FFF_FFFF; vals[6] = 32'h8000_0000;
    imms[0] = 8'h00; imms[1] = 8'h01; imms[2] = 8'hFF; imms[3] = 8'h7F;
    imms[4] = 8'h80; imms[5] = 8'h05;

    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_op = '0; in_rn = '0; in_rm = '0; in_imm = '0; in_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(t_flag == 1'b0, "R1 t after reset", {31'd0, t_flag}, 0);
    check(out_valid == 1'b0, "R1 out_valid after reset", {31'd0, out_valid}, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", {31'd0, in_ready}, 1);

    // R2 and R5: signed compare sweep followed by both branch kinds
    for (int i = 0; i < 7; i++) begin
      for (int j = 0; j < 7; j++) begin
        model_t = $signed(vals[i]) >= $signed(vals[j]);
        issue(3'd2, vals[i], vals[j], 8'h00, 0);
        check(t_flag == model_t, "R2 cmp-ge", {31'd0, t_flag}, {31'd0, model_t});
        branch_pair("after cmp-ge");
      end
    end

    // R3: equal-to-immediate sweep
    for (int i = 0; i < 7; i++) begin
      for (int j = 0; j < 6; j++) begin
        model_t = (vals[i] == sx(imms[j]));
        issue(3'd3, vals[i], 0, imms[j], 0);
        check(t_flag == model_t, "R3 cmp-eq-imm", {31'd0, t_flag}, {31'd0, model_t});
      end
    end
    issue(3'd3, 32'hFFFF_FF80, 0, 8'h80, 0);
    model_t = 1;
    check(t_flag == 1'b1, "R3 sign-extended 0x80", {31'd0, t_flag}, 1);

    // R4: add-immediate sums with T held at both levels
    for (int s = 0; s < 2; s++) begin
      model_t = s[0];
      issue(3'd3, s[0] ? 32'd0 : 32'd9, 0, 8'h00, 0);
      for (int i = 0; i < 7; i++) begin
        for (int j = 0; j < 6; j++) begin
          issue(3'd1, vals[i], 0, imms[j], 0);
          check(out_sum == vals[i] + sx(imms[j]), "R4 add sum", out_sum, vals[i] + sx(imms[j]));
          check(t_flag == model_t, "R4 add leaves t", {31'd0, t_flag}, {31'd0, model_t});
        end
      end
    end

    // R6: every displacement, two PCs
    for (int p = 0; p < 2; p++) begin
      for (int d = 0; d < 256; d++) begin
        logic [31:0] pc;
        logic [31:0] exp_t;
        pc = (p == 0) ? 32'h0000_1000 : 32'hFFFF_FFF0;
        exp_t = pc + 32'd4 + (sx(d[7:0]) << 1);
        issue((d % 2 == 0) ? 3'd4 : 3'd5, 0, 0, d[7:0], pc);
        check(out_target == exp_t, "R6 target", out_target, exp_t);
      end
    end

    // R8: idle and unused codes
    for (int c = 0; c < 3; c++) begin
      logic [2:0] code;
      code = (c == 0) ? 3'd0 : ((c == 1) ? 3'd6 : 3'd7);
      for (int s = 0; s < 2; s++) begin
        model_t = s[0];
        issue(3'd3, s[0] ? 32'd0 : 32'd1, 0, 8'h00, 0);
        issue(code, 32'd5, 32'd0, 8'h01, 32'h40);
        check(t_flag == model_t, "R8 t unchanged", {31'd0, t_flag}, {31'd0, model_t});
        check(out_sum == 0, "R8 sum zero", out_sum, 0);
        check(out_taken == 1'b0, "R8 not taken", {31'd0, out_taken}, 0);
      end
    end

    // R7: back-pressure
    issue(3'd3, 32'd1, 0, 8'h00, 0);
    model_t = 0;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 3'd1; in_rn = 32'd10; in_imm = 8'h03;
    @(negedge clk);
    held = out_sum;
    check(out_valid == 1'b1 && out_sum == 32'd13, "R7 result captured", out_sum, 13);
    in_op = 3'd2; in_rn = 32'd5; in_rm = 32'd1;
    @(negedge clk);
    check(in_ready == 1'b0, "R7 in_ready low while stalled", {31'd0, in_ready}, 0);
    @(negedge clk);
    check(out_sum == held, "R7 result held", out_sum, held);
    check(t_flag == 1'b0, "R7 stalled compare not applied", {31'd0, t_flag}, 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(t_flag == 1'b1, "R7 compare applied after release", {31'd0, t_flag}, 1);
    check(out_op == 3'd2, "R7 next result loaded", {29'd0, out_op}, 2);

    // R9: decrement, compare with zero, branch on true
    for (int n = 1; n <= 6; n++) begin
      r = n; iters = 0;
      for (int k = 0; k < 20; k++) begin
        issue(3'd1, r, 0, 8'hFF, 0);
        r = out_sum;
        iters++;
        issue(3'd3, r, 0, 8'h00, 0);
        issue(3'd4, 0, 0, 8'hF8, 32'h200);
        if (out_taken) break;
      end
      check(r == 0, "R9 loop exit register", r, 0);
      check(iters == n, "R9 loop iteration count", iters, n);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule